// File: doc/BRIEF.md
# Pipelined Burst SRAM with Zero Bus Turnaround

A synchronous single-port memory core whose data bus can switch between reading and writing on consecutive cycles with no idle cycle in between. Each operation goes through a fixed two-stage pipeline. The address and command are taken on one rising edge. Read data is driven on the following second edge, and write data is taken on that same second edge. Because the write data arrives late, it is parked in a pending-write register. It is committed to the array only when the next write's data arrives. Reads that target the parked address receive the parked bytes, merged lane by lane with the stored word.

The core starts a new access when the load/continue input is low and the chip is selected. When that input is high, the core continues the current burst at the next address inside a four-word block, in either linear or interleaved order. A read cycle with its output enable off still steps the burst but leaves the bus undriven. An active-low clock enable freezes the whole pipeline. A sleep request, passed through two sampling flops, blocks new operations and turns the bus driver off.

The shared data bus is modelled as a write-data input, a read-data output and a drive-enable output.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read whose address is taken on edge E drives its word on `rdata` with `rdata_oe` high from just after edge E+2, where E+1 and E+2 are the next two edges with `clk_en_n` low.
- R2: A write whose address is taken on edge E takes its data from `wdata` on edge E+2. Reads and writes may be issued on consecutive cycles in any mix.
- R3: Byte lane i is bits [i*LW +: LW] of the data word, with LW = 9 by default. It is written only when `lane_wr_n[i]` is low in the write's address cycle, and unselected lanes keep their contents. A write with every `lane_wr_n` bit high changes nothing.
- R4: A read issued right after a write to the same address returns the new bytes in the written lanes and the old contents in the other lanes.
- R5: With `order_sel` low, the n-th continuation cycle (`burst_cont` high) of a burst addresses base[1:0]+n modulo 4. The upper address bits stay those of the base, so the burst wraps within its four-word block.
- R6: With `order_sel` high, the n-th continuation cycle addresses base[1:0] XOR n, with the upper bits unchanged.
- R7: A cycle with `burst_cont` low and any chip select inactive (select means `cs0_n` low, `cs1` high and `cs2_n` low) performs no access. Continuation cycles that follow it also perform no access, and the bus is never driven for them.
- R8: A read cycle with `out_en_n` high advances the burst exactly like a normal read but leaves `rdata_oe` low in its data slot.
- R9: While `clk_en_n` is high, the inputs of that cycle are ignored, and `rdata`, `rdata_oe` and all pipeline state hold their values.
- R10: After `sleep_req` goes high, `rdata_oe` is low from the second clock edge onward and new operations are ignored. Normal operation resumes two edges after `sleep_req` falls.
- R11: After reset, `rdata_oe` is low and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the cycle |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_cont | input | 1 | 0: load a new address; 1: continue the burst |
| wr_n | input | 1 | 0: write, 1: read (sampled on load cycles) |
| lane_wr_n | input | LANES | Active-low per-lane write selects |
| out_en_n | input | 1 | Active-low output enable for the read slot |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| wdata | input | LANES*LW | Write data bus |
| rdata | output | LANES*LW | Read data bus |
| rdata_oe | output | 1 | Drive-enable for the read data bus |

## Verification
Single writes and reads to the same address, back to back, show whether the pending-write forwarding merges the correct lanes and whether commits happen in the right order. Four-beat write and read bursts, started at low-address values other than zero in both orders, show the difference between modulo addition and XOR stepping, and whether the burst wraps within its block. Dummy reads, deselected cycles, frozen clock-enable cycles and sleep each contain cycles that must not act. These are followed by reads of the affected words, so an operation that slips through becomes visible on the bus. A long stretch of random commands compares every cycle against a behavioural model.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low two address bits of the n-th beat of a burst
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       interleave);
        return interleave ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/pbs_sleep_sync.sv
module pbs_sleep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic asleep
);
    typedef struct packed {
        logic s0;
        logic s1;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s0 = sleep_req;
        st_d.s1 = st_q.s0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign asleep = st_q.s1;

    // R10
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(sleep_req, 2));

endmodule

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
    import pbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          asleep,
    input  logic          chip_sel,
    input  logic          burst_cont,
    input  logic          wr_n,
    input  logic          order_sel,
    input  logic [AW-1:0] addr,
    output op_e           cyc_op,
    output logic [AW-1:0] cyc_addr
);
    typedef struct packed {
        logic          active;
        logic          is_wr;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        cyc_op   = OP_IDLE;
        cyc_addr = st_q.base;
        if (asleep) begin
            st_d.active = 1'b0;
        end else if (!burst_cont) begin
            if (chip_sel) begin
                st_d.active = 1'b1;
                st_d.is_wr  = !wr_n;
                st_d.base   = addr;
                st_d.cnt    = 2'd0;
                cyc_op      = wr_n ? OP_READ : OP_WRITE;
                cyc_addr    = addr;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            st_d.cnt = st_q.cnt + 2'd1;
            cyc_op   = st_q.is_wr ? OP_WRITE : OP_READ;
            cyc_addr = {st_q.base[AW-1:2], burst_low(st_q.base[1:0], st_d.cnt, order_sel)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= '0;
        else if (!hold) st_q <= st_d;
    end

    // R7
    deselect_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !asleep && !burst_cont && !chip_sel) |=> !st_q.active);

    // R5
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !asleep && burst_cont && st_q.active) |=> (st_q.cnt == $past(st_q.cnt) + 2'd1));

endmodule

// File: rtl/pbs_store.sv
module pbs_store #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                wr_valid,
    input  logic [AW-1:0]       wr_addr,
    input  logic [LANES-1:0]    wr_mask,
    input  logic [LANES*LW-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [LANES*LW-1:0] rd_data
);
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic             valid;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] mask;
        logic [DW-1:0]    data;
    } pend_t;

    pend_t         pend_d, pend_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d  = mem_q;
        pend_d = pend_q;
        if (en && wr_valid) begin
            if (pend_q.valid) begin
                for (int l = 0; l < LANES; l++) begin
                    if (pend_q.mask[l])
                        mem_d[pend_q.addr][l*LW +: LW] = pend_q.data[l*LW +: LW];
                end
            end
            pend_d.valid = 1'b1;
            pend_d.addr  = wr_addr;
            pend_d.mask  = wr_mask;
            pend_d.data  = wr_data;
        end
    end

    logic hit;
    assign hit = pend_q.valid && (pend_q.addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_data[l*LW +: LW] = (hit && pend_q.mask[l]) ? pend_q.data[l*LW +: LW]
                                                              : mem_q[rd_addr][l*LW +: LW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            pend_q <= pend_d;
            mem_q  <= mem_d;
        end
    end

    // R4
    pending_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_valid) |=> (pend_q.valid && pend_q.addr == $past(wr_addr)));

    // R9
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pend_q));

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en_n,
    input  logic                cs0_n,
    input  logic                cs1,
    input  logic                cs2_n,
    input  logic                burst_cont,
    input  logic                wr_n,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic                out_en_n,
    input  logic                sleep_req,
    input  logic                order_sel,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata,
    output logic                rdata_oe
);
    localparam int DW = LANES * LW;

    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic             oe_n;
        logic [LANES-1:0] mask;
    } stage_t;

    typedef struct packed {
        stage_t        s1;
        stage_t        s2;
        logic [DW-1:0] dout;
        logic          den;
    } pipe_t;

    pipe_t         p_d, p_q;
    logic          asleep;
    logic          chip_sel;
    op_e           cyc_op;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] rd_data;

    assign chip_sel = !cs0_n && cs1 && !cs2_n;

    pbs_sleep_sync u_sleep (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .asleep    (asleep)
    );

    pbs_burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (clk_en_n),
        .asleep     (asleep),
        .chip_sel   (chip_sel),
        .burst_cont (burst_cont),
        .wr_n       (wr_n),
        .order_sel  (order_sel),
        .addr       (addr),
        .cyc_op     (cyc_op),
        .cyc_addr   (cyc_addr)
    );

    pbs_store #(.AW(AW), .LANES(LANES), .LW(LW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!clk_en_n),
        .wr_valid (p_q.s2.op == OP_WRITE),
        .wr_addr  (p_q.s2.addr),
        .wr_mask  (p_q.s2.mask),
        .wr_data  (wdata),
        .rd_addr  (p_q.s2.addr),
        .rd_data  (rd_data)
    );

    always_comb begin
        p_d = p_q;
        if (!clk_en_n) begin
            p_d.s1.op   = cyc_op;
            p_d.s1.addr = cyc_addr;
            p_d.s1.oe_n = out_en_n;
            p_d.s1.mask = ~lane_wr_n;
            p_d.s2      = p_q.s1;
            if (p_q.s2.op == OP_READ) begin
                p_d.dout = rd_data;
                p_d.den  = !p_q.s2.oe_n;
            end else begin
                p_d.den  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rdata    = p_q.dout;
    assign rdata_oe = p_q.den && !asleep;

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(p_q.dout) && $stable(p_q.den) && $stable(p_q.s1)));

    // R1
    drive_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.den) |-> ($past(p_q.s2.op) == OP_READ && !$past(clk_en_n)));

endmodule

// File: tb/tb_pipe_burst_sram.sv
module tb_pipe_burst_sram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic        burst_cont = 1'b0;
    logic        wr_n = 1'b1;
    logic [1:0]  lane_wr_n = 2'b11;
    logic        out_en_n = 1'b0;
    logic        sleep_req = 1'b0;
    logic        order_sel = 1'b0;
    logic [5:0]  addr = '0;
    logic [17:0] wdata;
    logic [17:0] rdata;
    logic        rdata_oe;

    pipe_burst_sram dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .sleep_req(sleep_req), .order_sel(order_sel),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R11";

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [17:0] mem_m [64];
    int          p1_op, p2_op;
    int          p1_addr, p2_addr;
    bit          p1_oe, p2_oe;
    logic [1:0]  p1_mask, p2_mask;
    logic [17:0] p1_wd, p2_wd;
    bit          b_act, b_wr;
    int          b_base, b_cnt;
    bit          sl1, sl2;
    bit          exp_den;
    logic [17:0] exp_dout;
    logic [17:0] cur_wd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem_m[i] = '0;
            p1_op = 0; p2_op = 0; p1_addr = 0; p2_addr = 0;
            p1_oe = 1; p2_oe = 1; p1_mask = 0; p2_mask = 0; p1_wd = 0; p2_wd = 0;
            b_act = 0; b_wr = 0; b_base = 0; b_cnt = 0;
            sl1 = 0; sl2 = 0; exp_den = 0; exp_dout = '0;
        end else begin
            bit old_sl;
            old_sl = sl2;
            sl2 = sl1;
            sl1 = sleep_req;
            if (!clk_en_n) begin
                int n_op, n_addr, lo;
                bit sel;
                n_op = 0; n_addr = 0;
                sel = !cs0_n && cs1 && !cs2_n;
                if (old_sl) b_act = 0;
                else if (!burst_cont) begin
                    if (sel) begin
                        b_act = 1; b_wr = !wr_n; b_base = int'(addr); b_cnt = 0;
                        n_op = wr_n ? 1 : 2; n_addr = int'(addr);
                    end else b_act = 0;
                end else if (b_act) begin
                    b_cnt = (b_cnt + 1) % 4;
                    lo = order_sel ? ((b_base % 4) ^ b_cnt) : (((b_base % 4) + b_cnt) % 4);
                    n_addr = (b_base / 4) * 4 + lo;
                    n_op = b_wr ? 2 : 1;
                end
                if (p2_op == 1) begin
                    exp_den = !p2_oe;
                    exp_dout = mem_m[p2_addr];
                end else exp_den = 0;
                if (p2_op == 2) begin
                    for (int l = 0; l < 2; l++)
                        if (p2_mask[l]) mem_m[p2_addr][l*9 +: 9] = wdata[l*9 +: 9];
                end
                p2_op = p1_op; p2_addr = p1_addr; p2_oe = p1_oe; p2_mask = p1_mask; p2_wd = p1_wd;
                p1_op = n_op; p1_addr = n_addr; p1_oe = out_en_n; p1_mask = ~lane_wr_n; p1_wd = cur_wd;
            end
        end
    end

    logic [17:0] rd_log [$];

    always @(negedge clk) begin
        if (!rst_n) begin
            wdata <= '0;
        end else begin
            bit vis;
            vis = exp_den && !sl2;
            check(rdata_oe == vis, {phase, " bus enable"}, 32'(rdata_oe), 32'(vis));
            if (vis && rdata_oe)
                check(rdata == exp_dout, {phase, " read data"}, 32'(rdata), 32'(exp_dout));
            if (rdata_oe) rd_log.push_back(rdata);
            wdata <= (p2_op == 2) ? p2_wd : 18'h0;
        end
    end

    task automatic drive(input bit cen, input bit sel, input bit cont, input bit wn,
                         input logic [1:0] bw, input bit oen, input int a, input logic [17:0] wd);
        @(negedge clk);
        clk_en_n = cen; cs0_n = !sel; cs1 = sel; cs2_n = !sel;
        burst_cont = cont; wr_n = wn; lane_wr_n = bw; out_en_n = oen;
        addr = a[5:0]; cur_wd = wd;
    endtask

    task automatic wr1(input int a, input logic [17:0] d, input logic [1:0] bw);
        drive(0, 1, 0, 0, bw, 1, a, d);
    endtask
    task automatic rd1(input int a);
        drive(0, 1, 0, 1, 2'b11, 0, a, 0);
    endtask
    task automatic cont_wr(input logic [17:0] d);
        drive(0, 1, 1, 0, 2'b00, 1, 0, d);
    endtask
    task automatic cont_rd(input bit oen);
        drive(0, 1, 1, 1, 2'b11, oen, 0, 0);
    endtask
    task automatic idle();
        drive(0, 0, 0, 1, 2'b11, 0, 0, 0);
    endtask
    task automatic flush();
        repeat (4) idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(rdata_oe == 1'b0, "R11 idle bus after reset", 32'(rdata_oe), 0);

        // R11: array starts at zero
        rd_log.delete(); rd1(3); flush();
        check(rd_log.size() == 1 && rd_log[0] == 18'h0, "R11 reset content", rd_log.size() > 0 ? 32'(rd_log[0]) : 32'hdead, 0);

        // R2 R4: write then read on the next cycle
        phase = "R4";
        rd_log.delete(); wr1(5, 18'h2A5A5, 2'b00); rd1(5); flush();
        check(rd_log.size() == 1 && rd_log[0] == 18'h2A5A5, "R4 R2 back-to-back", rd_log.size() > 0 ? 32'(rd_log[0]) : 32'hdead, 32'h2A5A5);

        // R3: lane-selective writes, and a write with no lanes
        phase = "R3";
        rd_log.delete();
        wr1(5, 18'h3FFFF, 2'b10); rd1(5);
        wr1(5, 18'h00000, 2'b11); rd1(5);
        wr1(5, 18'h00000, 2'b01); rd1(5);
        flush();
        check(rd_log.size() == 3, "R3 read count", rd_log.size(), 3);
        if (rd_log.size() == 3) begin
            check(rd_log[0] == 18'h2A5FF, "R3 R4 low lane merge", 32'(rd_log[0]), 32'h2A5FF);
            check(rd_log[1] == 18'h2A5FF, "R3 no-lane write", 32'(rd_log[1]), 32'h2A5FF);
            check(rd_log[2] == 18'h001FF, "R3 high lane write", 32'(rd_log[2]), 32'h001FF);
        end

        // R5: linear write burst from low bits 2, then reads
        phase = "R5";
        order_sel = 1'b0;
        rd_log.delete();
        wr1(10, 18'h100, 2'b00); cont_wr(18'h101); cont_wr(18'h102); cont_wr(18'h103);
        idle(); rd1(8); rd1(9); rd1(10); rd1(11); flush();
        check(rd_log.size() == 4 && rd_log[0] == 18'h102 && rd_log[1] == 18'h103
              && rd_log[2] == 18'h100 && rd_log[3] == 18'h101, "R5 linear write wrap",
              rd_log.size() > 0 ? 32'(rd_log[0]) : 32'hdead, 32'h102);
        rd_log.delete();
        rd1(9); cont_rd(0); cont_rd(0); cont_rd(0); flush();
        check(rd_log.size() == 4 && rd_log[0] == 18'h103 && rd_log[1] == 18'h100
              && rd_log[2] == 18'h101 && rd_log[3] == 18'h102, "R5 linear read wrap",
              rd_log.size() > 1 ? 32'(rd_log[1]) : 32'hdead, 32'h100);

        // R6: interleaved order
        phase = "R6";
        order_sel = 1'b1;
        rd_log.delete();
        rd1(9); cont_rd(0); cont_rd(0); cont_rd(0); flush();
        check(rd_log.size() == 4 && rd_log[0] == 18'h103 && rd_log[1] == 18'h102
              && rd_log[2] == 18'h101 && rd_log[3] == 18'h100, "R6 interleaved read",
              rd_log.size() > 1 ? 32'(rd_log[1]) : 32'hdead, 32'h102);
        rd_log.delete();
        wr1(14, 18'h200, 2'b00); cont_wr(18'h201); cont_wr(18'h202); cont_wr(18'h203);
        idle(); rd1(12); rd1(13); flush();
        check(rd_log.size() == 2 && rd_log[0] == 18'h202 && rd_log[1] == 18'h203, "R6 interleaved write",
              rd_log.size() > 0 ? 32'(rd_log[0]) : 32'hdead, 32'h202);
        order_sel = 1'b0;

        // R8: dummy reads advance the burst without driving
        phase = "R8";
        rd_log.delete();
        drive(0, 1, 0, 1, 2'b11, 1, 8, 0); cont_rd(1); cont_rd(0); cont_rd(0); flush();
        check(rd_log.size() == 2 && rd_log[0] == 18'h100 && rd_log[1] == 18'h101, "R8 dummy read",
              rd_log.size(), 2);

        // R7: deselect, continuation after deselect, deselected write attempt
        phase = "R7";
        rd_log.delete();
        drive(0, 0, 0, 1, 2'b11, 0, 8, 0);
        drive(0, 0, 1, 1, 2'b11, 0, 8, 0);
        drive(0, 0, 0, 0, 2'b00, 1, 8, 18'h3);
        drive(0, 1, 1, 0, 2'b00, 1, 8, 18'h7);
        flush();
        check(rd_log.size() == 0, "R7 no access when deselected", rd_log.size(), 0);
        rd1(8); flush();
        check(rd_log.size() == 1 && rd_log[0] == 18'h102, "R7 content untouched",
              rd_log.size() > 0 ? 32'(rd_log[0]) : 32'hdead, 32'h102);

        // R9: frozen cycles are ignored
        phase = "R9";
        rd_log.delete();
        rd1(10);
        repeat (3) drive(1, 1, 0, 0, 2'b00, 0, 11, 18'h5);
        idle(); flush();
        rd1(11); flush();
        check(rd_log.size() == 2 && rd_log[0] == 18'h100 && rd_log[1] == 18'h101, "R9 freeze ignored",
              rd_log.size(), 2);

        // R10: sleep blocks operations and the bus
        phase = "R10";
        rd_log.delete();
        @(negedge clk); sleep_req = 1'b1;
        idle(); idle(); idle();
        rd1(8); wr1(8, 18'h3FFFF, 2'b00); rd1(9); idle(); idle(); idle();
        #1;
        check(rd_log.size() == 0 && rdata_oe == 1'b0, "R10 asleep", rd_log.size(), 0);
        @(negedge clk); sleep_req = 1'b0;
        idle(); idle(); idle();
        rd1(8); flush();
        check(rd_log.size() == 1 && rd_log[0] == 18'h102, "R10 wake", rd_log.size() > 0 ? 32'(rd_log[0]) : 32'hdead, 32'h102);

        // random mix against the model (R1 R2 R4 R5 R6 R7 R8 R9)
        phase = "R1 random";
        for (int i = 0; i < 600; i++) begin
            if (i % 150 == 0) begin
                flush();
                order_sel = $urandom_range(0, 1);
            end
            drive(($urandom_range(0, 4) == 0), ($urandom_range(0, 5) != 0), $urandom_range(0, 1),
                  $urandom_range(0, 1), 2'($urandom_range(0, 3)), ($urandom_range(0, 5) == 0),
                  int'($urandom_range(0, 15)), 18'($urandom));
        end
        flush();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule